// File: doc/BRIEF.md
# Prescaled PWM time-base counter

This block produces the time reference for a PWM generator. A 16-bit counter advances once per prescaled tick. It counts up, down or up-down between zero and a programmable period, and it can also be frozen. Each time the counter arrives at zero or at the period, it raises a one-clock strobe. Compare and action stages further down the chip use the count and these strobes to build waveforms.

A small write port loads two things. One is a control word, which holds the count mode, the run mode, the period-load mode and two prescaler codes. The other is the period. The period can be written straight into the active register, or into a shadow copy that becomes active the next time the counter reaches zero.

The run mode decides how the counter stops. It can halt at once, halt after it finishes the cycle in progress, or keep running freely.

Top module: `pwm_timebase`

## Requirements
- R1: Synchronous reset clears the count, both periods, the control word and both strobes. The counter then stays at 0, with no strobes, until a control word with a running run mode is written.
- R2: Write port addressing: `wr_sel`=0 writes the control word and `wr_sel`=1 writes the period.
- R3: Control bits 1:0 select the count mode, and code 00 is up mode. In up mode the count steps 0,1,…,P and then wraps to 0.
- R4: Count mode code 01 is down mode. The count steps down to 0 and then reloads P. Starting from 0, the first count event loads P.
- R5: Count mode code 10 is up-down mode. The count rises from 0 to P and falls back to 0, repeating with a cycle of 2·P events. With P=0 the count stays at 0.
- R6: Count mode code 11 is frozen. The count holds and no strobe is raised.
- R7: One count event occurs every (2^c)·(h=0 ? 1 : 2·h) clocks. c is the code in control bits 12:10 and h is the code in control bits 9:7.
- R8: Run mode sits in control bits 15:14. With 00 the counter stops immediately and holds its value. With 10 or 11 it runs freely.
- R9: With run mode 01 the counter finishes the cycle in progress and then holds. The cycle ends at P in up mode, and at 0 in down and up-down modes.
- R10: Control bit 3 selects how a period write lands. With 1 the write goes to both the active and the shadow period. With 0 the write goes only to the shadow, which is copied to the active period on the count event that brings the counter to 0.
- R11: `zero_evt` and `prd_evt` go high for exactly one clock. They are high in the same clock as the count value 0 or P that a count event produced. They are never raised while the counter is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = period |
| wr_data | input | 16 | Write data |
| count | output | CW (16) | Time-base count |
| zero_evt | output | 1 | Count reached zero |
| prd_evt | output | 1 | Count reached the active period |

## Verification
Two functions can fall in the same cycle: the zero strobe and the period strobe. When the active period is 0, every count event lands on a value that is both zero and the period, so both strobes must rise together.

The sweep provokes this case by programming P=0 in every count mode and at every divider setting. It expects both strobes on exactly those clocks where the arithmetic model places a count event.

The shadow test reaches the same coincidence from the other side. There the active period is still 0 when the first event arrives, so that first event raises both strobes and installs the shadow value in the same clock.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [15:0]   wr_data,
  output logic [CW-1:0] count,
  output logic          zero_evt,
  output logic          prd_evt
);
  localparam int MAXDIV = 14 * 128;
  localparam int PW     = $clog2(MAXDIV + 1);
  localparam logic [1:0] M_UP = 2'b00, M_DN = 2'b01, M_UD = 2'b10, M_FRZ = 2'b11;

  logic [15:0]   ctrl;
  logic [CW-1:0] prd_act, prd_shd, nxt;
  logic [PW-1:0] pcnt, div_m1;
  logic [3:0]    hs_mul;
  logic          dir_dn, nxt_dn, done, hold, tick;

  wire [1:0] mode = ctrl[1:0];
  wire [1:0] run  = ctrl[15:14];
  wire       ld_now = ctrl[3];

  assign hs_mul = (ctrl[9:7] == 3'd0) ? 4'd1 : {ctrl[9:7], 1'b0};
  assign div_m1 = (PW'(hs_mul) << ctrl[12:10]) - 1'b1;

  always_comb begin
    case (mode)
      M_UP:    done = (count >= prd_act);
      M_DN:    done = (count == '0);
      M_UD:    done = (count == '0) && dir_dn;
      default: done = 1'b1;
    endcase
  end

  assign hold = (mode == M_FRZ) || (run == 2'b00) || (run == 2'b01 && done);
  assign tick = !hold && (pcnt >= div_m1);

  always_comb begin
    nxt    = count;
    nxt_dn = dir_dn;
    case (mode)
      M_UP: begin
        nxt    = (count >= prd_act) ? '0 : count + 1'b1;
        nxt_dn = 1'b0;
      end
      M_DN: begin
        nxt    = (count == '0) ? prd_act : count - 1'b1;
        nxt_dn = 1'b1;
      end
      M_UD: begin
        if (!dir_dn) begin
          if (count >= prd_act) begin
            nxt_dn = 1'b1;
            nxt    = (count == '0) ? '0 : count - 1'b1;
          end else begin
            nxt = count + 1'b1;
          end
        end else if (count == '0) begin
          nxt_dn = 1'b0;
          nxt    = (prd_act == '0) ? '0 : CW'(1);
        end else begin
          nxt = count - 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || hold || tick) pcnt <= '0;
    else                     pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      prd_act  <= '0;
      prd_shd  <= '0;
      count    <= '0;
      dir_dn   <= 1'b0;
      zero_evt <= 1'b0;
      prd_evt  <= 1'b0;
    end else begin
      zero_evt <= tick && (nxt == '0);
      prd_evt  <= tick && (nxt == prd_act);
      if (tick) begin
        count  <= nxt;
        dir_dn <= nxt_dn;
        if (!ld_now && nxt == '0) prd_act <= prd_shd;
      end
      if (wr_en && !wr_sel) ctrl <= wr_data;
      if (wr_en && wr_sel) begin
        prd_shd <= wr_data[CW-1:0];
        if (ld_now) prd_act <= wr_data[CW-1:0];
      end
    end
  end

  p_halt_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (run == 2'b00) |=> $stable(count));

  p_frozen_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == M_FRZ) |=> ($stable(count) && !zero_evt && !prd_evt));

  p_up_step_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == M_UP && count < prd_act) |=> (count == $past(count) + 1'b1));

  p_down_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == M_DN && count == '0) |=> (count == $past(prd_act)));

  p_pulse_single_r11: assert property (@(posedge clk) disable iff (rst)
    (zero_evt && div_m1 != '0 && !(wr_en && !wr_sel)) |=> !zero_evt);

  p_strobe_needs_run_r11: assert property (@(posedge clk) disable iff (rst)
    (zero_evt || prd_evt) |-> $past(!hold));

  p_shadow_copy_r10: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_now && nxt == '0 && !(wr_en && wr_sel)) |=> (prd_act == $past(prd_shd)));
endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        zero_evt, prd_evt;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timebase i_pwm_timebase (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .count(count), .zero_evt(zero_evt), .prd_evt(prd_evt));

  function automatic logic [15:0] cw(input logic [1:0] run, input logic [2:0] c,
                                     input logic [2:0] h, input logic ld, input logic [1:0] md);
    return {run, 1'b0, c, h, 3'b000, ld, 1'b0, md};
  endfunction

  function automatic int model(input int md, input int p, input int k);
    if (p == 0) return 0;
    if (md == 0) return k % (p + 1);
    if (md == 1) return (p + 1 - (k % (p + 1))) % (p + 1);
    begin
      int m = k % (2 * p);
      return (m <= p) ? m : 2 * p - m;
    end
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wait_then_ctrl(input int v, input logic [15:0] d);
    while (count != v) @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic hold_check(input string req, input int v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, "held count", count, v);
      chk(req, "no zero strobe", zero_evt, 0);
      chk(req, "no period strobe", prd_evt, 0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int plist [4] = '{0, 1, 3, 5};
    int clist [5] = '{0, 1, 0, 0, 2};
    int hlist [5] = '{0, 0, 1, 3, 2};
    string mtag [3] = '{"R3", "R4", "R5"};
    int seq [8] = '{3, 4, 0, 1, 2, 0, 1, 2};
    int v;

    // R1: reset state and no motion afterwards
    do_reset();
    chk("R1", "count", count, 0);
    chk("R1", "zero strobe", zero_evt, 0);
    chk("R1", "period strobe", prd_evt, 0);
    hold_check("R1", 0, 10);

    // R2 R3 R4 R5 R7 R10 R11: sweep modes, periods, dividers (direct load)
    for (int md = 0; md < 3; md++)
      for (int pi = 0; pi < 4; pi++)
        for (int di = 0; di < 5; di++) begin
          int p = plist[pi];
          int c = clist[di];
          int h = hlist[di];
          int d = (h == 0 ? 1 : 2 * h) << c;
          int nt = d * (2 * p + 2) * 2 + d;
          do_reset();
          wr(1'b0, cw(2'b00, 3'(c), 3'(h), 1'b1, 2'(md)));
          wr(1'b1, 16'(p));
          wr(1'b0, cw(2'b11, 3'(c), 3'(h), 1'b1, 2'(md)));
          for (int n = 1; n <= nt; n++) begin
            int e;
            bit ev;
            @(negedge clk);
            e  = model(md, p, n / d);
            ev = (n % d) == 0;
            chk({mtag[md], "/R7"}, "count", count, e);
            chk("R11", "zero strobe", zero_evt, int'(ev && e == 0));
            chk("R11", "period strobe", prd_evt, int'(ev && e == p));
          end
        end

    // R10: shadow load applied at the zero event
    do_reset();
    wr(1'b0, cw(2'b00, 3'd0, 3'd0, 1'b0, 2'b00));
    wr(1'b1, 16'd4);
    wr(1'b0, cw(2'b11, 3'd0, 3'd0, 1'b0, 2'b00));
    @(negedge clk);
    chk("R10", "first count", count, 0);
    chk("R10", "zero strobe with old period 0", zero_evt, 1);
    chk("R10", "period strobe with old period 0", prd_evt, 1);
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk);
      chk("R10", "count after shadow copy", count, n % 5);
    end
    while (count != 2) @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'd2;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); wr_en = 1'b0;
      chk("R10", "shadow write deferred", count, seq[i]);
    end

    // R8: stop immediately
    wr(1'b0, cw(2'b00, 3'd0, 3'd0, 1'b0, 2'b00));
    v = count;
    hold_check("R8", v, 15);

    // R6: frozen mode while the run mode says free run
    wr(1'b0, cw(2'b11, 3'd0, 3'd0, 1'b1, 2'b00));
    repeat (3) @(negedge clk);
    wr(1'b0, cw(2'b11, 3'd0, 3'd0, 1'b1, 2'b11));
    v = count;
    hold_check("R6", v, 15);

    // R9: finish the cycle in up mode, then hold at the period
    do_reset();
    wr(1'b0, cw(2'b00, 3'd0, 3'd0, 1'b1, 2'b00));
    wr(1'b1, 16'd5);
    wr(1'b0, cw(2'b11, 3'd0, 3'd0, 1'b1, 2'b00));
    wait_then_ctrl(2, cw(2'b01, 3'd0, 3'd0, 1'b1, 2'b00));
    chk("R9", "up count", count, 3);
    @(negedge clk); chk("R9", "up count", count, 4);
    @(negedge clk); chk("R9", "up count", count, 5);
    chk("R9", "period strobe at end", prd_evt, 1);
    hold_check("R9", 5, 10);

    // R9: finish the cycle in down mode, then hold at zero
    do_reset();
    wr(1'b0, cw(2'b00, 3'd0, 3'd0, 1'b1, 2'b01));
    wr(1'b1, 16'd5);
    wr(1'b0, cw(2'b11, 3'd0, 3'd0, 1'b1, 2'b01));
    wait_then_ctrl(3, cw(2'b01, 3'd0, 3'd0, 1'b1, 2'b01));
    chk("R9", "down count", count, 2);
    @(negedge clk); chk("R9", "down count", count, 1);
    @(negedge clk); chk("R9", "down count", count, 0);
    chk("R9", "zero strobe at end", zero_evt, 1);
    hold_check("R9", 0, 10);

    summary();
    $finish;
  end
endmodule